// File: doc/BRIEF.md
# Color Register Cycle Controller

This block holds a 4-bit color value, one bit per I/O block of a memory array, and the strobe decoding that loads it from the data bus and drives it back out. The row strobe, column strobe, write strobe and output-enable strobe are all active low. Together with a special-function select, these five strobes come from outside the clock domain. Each passes through a two-flop synchroniser, and the block detects edges on the synchronised copies.

The type of each row cycle is set by the levels of the other four controls when the row strobe falls. If column strobe, write strobe, output enable and the special-function select are all high, the cycle is a color register cycle. In that cycle the register takes the bus value on the later of the column-strobe and write-strobe falls. If the column strobe falls while the write strobe is still high, the cycle is a read: the register drives the bus for as long as output enable stays low. Each color register cycle also raises a one-cycle refresh request for the row address present when the row strobe fell.

Top module: `color_reg_ctrl`

## Requirements
- R1: After synchronous reset the register reads back zero, `dq_oe_o` is low and `refresh_o` is low.
- R2: A row cycle is a color register cycle only if column strobe, write strobe, output enable and special-function select are all high when the row strobe falls. In any other row cycle, strobe activity leaves the register unchanged and raises no refresh request.
- R3: If the write strobe falls first, the register captures the bus value at the later column-strobe fall. The bus value present at the write-strobe fall is not kept.
- R4: If the column strobe falls first, the register waits and captures the bus value at the later write-strobe fall.
- R5: If the column strobe and write strobe fall in the same synchronised cycle, the register loads the bus value once.
- R6: In a read cycle (column strobe falls while write strobe is high), `dq_oe_o` is high while output enable is low, and `dq_o` carries the register contents.
- R7: `dq_oe_o` is low whenever output enable is high, and it drops once the row strobe rises, even if output enable is still low.
- R8: If the write strobe falls during a read cycle, the drive ends and the register loads the bus value.
- R9: Each color register cycle (load or read) gives exactly one `refresh_o` pulse, one clock wide. `refresh_row_o` then holds the row address sampled when the row strobe fell.
- R10: After a load, further write-strobe or column-strobe activity in the same row cycle leaves the register unchanged until the row strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low, asynchronous |
| cas_n_i | input | 1 | Column strobe, active low, asynchronous |
| we_n_i | input | 1 | Write strobe, active low, asynchronous |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| dsf_i | input | 1 | Special-function select |
| row_addr_i | input | ROW_W | Row address, stable around the row-strobe fall |
| dq_i | input | COLOR_W | Data bus, inbound half |
| dq_o | output | COLOR_W | Data bus, outbound half (register contents) |
| dq_oe_o | output | 1 | Outbound drive enable for the data bus |
| refresh_o | output | 1 | One-cycle refresh request for the latched row |
| refresh_row_o | output | ROW_W | Row to refresh |

## Verification
Two functions can land in the same cycle. The first pair is the column-strobe fall and the write-strobe fall, which must produce one load and not a read. The bench provokes this by changing both strobes on one clock edge and then reading the value back. The second pair is the end of a read window and a load: the write strobe falls while the register is driving the bus. Here the bench expects `dq_oe_o` to drop and a later read cycle to return the bus value that was present at that fall.

// File: rtl/color_reg_pkg.sv
// Shared types for the color register cycle controller.
// Assumes strobe vectors are packed in the bit order given by the STB_* indices.
package color_reg_pkg;
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_WE  = 2;
    localparam int STB_OE  = 3;
    localparam int STB_DSF = 4;
    localparam int STB_W   = 5;

    // Idle levels: active-low strobes rest high, special-function select rests low.
    localparam logic [STB_W-1:0] STB_IDLE = 5'b01111;

    typedef enum logic [2:0] {
        CYC_IDLE,       // waiting for a row-strobe fall
        CYC_OTHER,      // non-color row cycle, ignored
        CYC_ARM,        // color cycle, neither column nor write strobe fallen
        CYC_CAS_FIRST,  // column strobe fell with write strobe high: read window
        CYC_WE_FIRST,   // write strobe fell, waiting for column strobe
        CYC_DONE        // load done, waiting for row-strobe rise
    } cyc_state_t;
endpackage

// File: rtl/strobe_sync.sv
// Two-flop synchroniser with edge detection for a vector of control inputs.
// Assumes every input bit is an independent level.
// Edges are reported for one cycle after the second flop.
module strobe_sync #(
    parameter int          W       = 5,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] fall_o,
    output logic [W-1:0] rise_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q, prev_q;

        // Two-stage capture plus one history flop for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
                prev_q <= RST_VAL[i];
            end else begin
                meta_q <= async_i[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level_o[i] = sync_q;
        assign fall_o[i]  = prev_q & ~sync_q;
        assign rise_o[i]  = ~prev_q & sync_q;
    end
endmodule

// File: rtl/cycle_decoder.sv
// Decodes row cycles from synchronised strobes.
// It chooses the color register cycle at the row-strobe fall, issues a single
// load on the later of the column/write strobe falls, opens the read window,
// and raises the refresh request.
// Assumes the row address is stable around the row-strobe fall.
module cycle_decoder
    import color_reg_pkg::*;
#(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STB_W-1:0] lvl_i,
    input  logic [STB_W-1:0] fall_i,
    input  logic [STB_W-1:0] rise_i,
    input  logic [ROW_W-1:0] row_addr_i,
    output logic             load_o,
    output logic             drive_o,
    output logic             refresh_o,
    output logic [ROW_W-1:0] refresh_row_o
);
    cyc_state_t state_q, state_d;
    logic       color_sel;
    logic       cas_f, we_f;

    assign cas_f     = fall_i[STB_CAS];
    assign we_f      = fall_i[STB_WE];
    assign color_sel = lvl_i[STB_CAS] & lvl_i[STB_WE] & lvl_i[STB_OE] & lvl_i[STB_DSF];

    // Next-state and load decode; a row-strobe rise ends any cycle first.
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        case (state_q)
            CYC_IDLE: begin
                if (fall_i[STB_RAS]) state_d = color_sel ? CYC_ARM : CYC_OTHER;
            end
            CYC_ARM: begin
                if (cas_f && we_f) begin
                    load_o  = 1'b1;
                    state_d = CYC_DONE;
                end else if (cas_f) begin
                    state_d = CYC_CAS_FIRST;
                end else if (we_f) begin
                    state_d = CYC_WE_FIRST;
                end
            end
            CYC_CAS_FIRST: begin
                if (we_f) begin
                    load_o  = 1'b1;
                    state_d = CYC_DONE;
                end
            end
            CYC_WE_FIRST: begin
                if (cas_f) begin
                    load_o  = 1'b1;
                    state_d = CYC_DONE;
                end
            end
            default: ;
        endcase
        if (state_q != CYC_IDLE && rise_i[STB_RAS]) begin
            state_d = CYC_IDLE;
            load_o  = 1'b0;
        end
    end

    // Cycle state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CYC_IDLE;
        else        state_q <= state_d;
    end

    // Refresh request pulse and row latch at the color-cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_o     <= 1'b0;
            refresh_row_o <= '0;
        end else begin
            refresh_o <= (state_q == CYC_IDLE) && fall_i[STB_RAS] && color_sel;
            if ((state_q == CYC_IDLE) && fall_i[STB_RAS] && color_sel)
                refresh_row_o <= row_addr_i;
        end
    end

    // Read window: column strobe fell with write strobe high, output enable low.
    assign drive_o = (state_q == CYC_CAS_FIRST) && !lvl_i[STB_OE] && !lvl_i[STB_RAS];

    assert_one_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
    assert_load_strobes_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (!lvl_i[STB_CAS] && !lvl_i[STB_WE] && !lvl_i[STB_RAS]));
    assert_refresh_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |=> !refresh_o);
    assert_no_load_after_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |-> !load_o);
endmodule

// File: rtl/color_reg_ctrl.sv
// Top: color register with strobe synchronisation, cycle decode and bus drive.
// Assumes the data bus is stable from before the loading strobe fall until
// the synchronised fall has been seen (three clocks).
module color_reg_ctrl
    import color_reg_pkg::*;
#(
    parameter int COLOR_W = 4,
    parameter int ROW_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ras_n_i,
    input  logic               cas_n_i,
    input  logic               we_n_i,
    input  logic               oe_n_i,
    input  logic               dsf_i,
    input  logic [ROW_W-1:0]   row_addr_i,
    input  logic [COLOR_W-1:0] dq_i,
    output logic [COLOR_W-1:0] dq_o,
    output logic               dq_oe_o,
    output logic               refresh_o,
    output logic [ROW_W-1:0]   refresh_row_o
);
    logic [STB_W-1:0]   strobe_raw, strobe_lvl, strobe_fall, strobe_rise;
    logic [COLOR_W-1:0] color_q;
    logic               load;

    assign strobe_raw = {dsf_i, oe_n_i, we_n_i, cas_n_i, ras_n_i};

    strobe_sync #(
        .W       (STB_W),
        .RST_VAL (STB_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (strobe_raw),
        .level_o (strobe_lvl),
        .fall_o  (strobe_fall),
        .rise_o  (strobe_rise)
    );

    cycle_decoder #(
        .ROW_W (ROW_W)
    ) u_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .lvl_i         (strobe_lvl),
        .fall_i        (strobe_fall),
        .rise_i        (strobe_rise),
        .row_addr_i    (row_addr_i),
        .load_o        (load),
        .drive_o       (dq_oe_o),
        .refresh_o     (refresh_o),
        .refresh_row_o (refresh_row_o)
    );

    // Color register: cleared by reset, loaded from the bus on a decoded load.
    always_ff @(posedge clk) begin
        if (!rst_n)    color_q <= '0;
        else if (load) color_q <= dq_i;
    end

    assign dq_o = color_q;

    assert_drive_needs_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> !strobe_lvl[STB_OE]);
    assert_drive_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o && $past(dq_oe_o)) |-> $stable(dq_o));
    assert_reg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(color_q));
    assert_no_drive_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !dq_oe_o);
endmodule

// File: tb/color_reg_ctrl_tb.sv
module color_reg_ctrl_tb;
    localparam int COLOR_W = 4;
    localparam int ROW_W   = 9;
    localparam int NVEC    = 6;
    // Vector: {order[1:0], data[3:0], row[8:0]}; order 0 = write strobe first,
    // 1 = column strobe first, 2 = both together.
    localparam logic [14:0] VEC [NVEC] = '{
        {2'd0, 4'hA, 9'd17},
        {2'd1, 4'h5, 9'd300},
        {2'd2, 4'hF, 9'd0},
        {2'd0, 4'h3, 9'd511},
        {2'd1, 4'hC, 9'd42},
        {2'd2, 4'h6, 9'd128}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, dsf = 1'b0;
    logic [ROW_W-1:0]   row = '0;
    logic [COLOR_W-1:0] dq_i = '0;
    logic [COLOR_W-1:0] dq_o;
    logic               dq_oe, refresh;
    logic [ROW_W-1:0]   refresh_row;

    int total = 0, bad = 0, ref_cnt = 0, exp_ref = 0;
    logic [ROW_W-1:0] last_row = '0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    color_reg_ctrl #(.COLOR_W(COLOR_W), .ROW_W(ROW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
        .we_n_i(we_n), .oe_n_i(oe_n), .dsf_i(dsf), .row_addr_i(row),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe),
        .refresh_o(refresh), .refresh_row_o(refresh_row)
    );

    // Count refresh pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && refresh) begin
            ref_cnt  = ref_cnt + 1;
            last_row = refresh_row;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic end_cycle();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        settle();
    endtask

    task automatic start_color(input logic [ROW_W-1:0] r);
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; dsf = 1'b1; row = r;
        settle();
        ras_n = 1'b0;
        settle();
        dsf = 1'b0;
    endtask

    task automatic load_cycle(input logic [1:0] order, input logic [3:0] d,
                              input logic [ROW_W-1:0] r);
        start_color(r);
        exp_ref++;
        if (order == 2'd0) begin
            dq_i = ~d; we_n = 1'b0; settle();
            dq_i = d;  cas_n = 1'b0; settle();
        end else if (order == 2'd1) begin
            dq_i = ~d; cas_n = 1'b0; settle();
            dq_i = d;  we_n = 1'b0; settle();
        end else begin
            dq_i = d; cas_n = 1'b0; we_n = 1'b0; settle();
        end
        end_cycle();
    endtask

    task automatic read_back(output logic [3:0] val, output logic oe_seen);
        start_color(9'd5);
        exp_ref++;
        cas_n = 1'b0; settle();
        oe_n = 1'b0;  settle();
        val = dq_o; oe_seen = dq_oe;
        oe_n = 1'b1;  settle();
        check(!dq_oe, "R7 drive off with oe high", dq_oe, 0);
        end_cycle();
    endtask

    initial begin
        logic [3:0] v;
        logic       s;
        repeat (3) @(negedge clk);
        check(dq_o == 4'h0 && !dq_oe && !refresh, "R1 reset state", {dq_oe, dq_o}, 0);
        rst_n = 1'b1;
        settle();
        check(dq_o == 4'h0 && !dq_oe && !refresh, "R1 after reset", {dq_oe, dq_o}, 0);

        // Table walk: load by each strobe order, then read back.
        for (int i = 0; i < NVEC; i++) begin
            load_cycle(VEC[i][14:13], VEC[i][12:9], VEC[i][8:0]);
            check(ref_cnt == exp_ref && last_row == VEC[i][8:0], "R9 refresh row",
                  last_row, VEC[i][8:0]);
            read_back(v, s);
            check(s == 1'b1, "R6 drive in read", s, 1);
            check(v == VEC[i][12:9],
                  (VEC[i][14:13] == 2'd0) ? "R3 later cas" :
                  (VEC[i][14:13] == 2'd1) ? "R4 later we" : "R5 same cycle", v, VEC[i][12:9]);
        end

        // R2: special-function select low at row fall -> no load, no refresh.
        dsf = 1'b0; row = 9'd77; settle();
        ras_n = 1'b0; settle();
        dq_i = 4'h1; we_n = 1'b0; cas_n = 1'b0; settle();
        end_cycle();
        check(ref_cnt == exp_ref, "R2 no refresh on other cycle", ref_cnt, exp_ref);
        read_back(v, s);
        check(v == 4'h6, "R2 register unchanged", v, 4'h6);

        // R2: output enable low at row fall -> not a color cycle.
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; dsf = 1'b1; settle();
        ras_n = 1'b0; settle();
        dsf = 1'b0; dq_i = 4'h2; we_n = 1'b0; cas_n = 1'b0; settle();
        end_cycle();
        check(ref_cnt == exp_ref, "R2 oe low no refresh", ref_cnt, exp_ref);
        read_back(v, s);
        check(v == 4'h6, "R2 oe low no load", v, 4'h6);

        // R8: write strobe falls during the read window.
        start_color(9'd9);
        exp_ref++;
        cas_n = 1'b0; settle();
        oe_n = 1'b0;  settle();
        check(dq_oe == 1'b1 && dq_o == 4'h6, "R6 driving before we fall", dq_o, 4'h6);
        dq_i = 4'h9; we_n = 1'b0; settle();
        check(!dq_oe, "R8 drive ends on we fall", dq_oe, 0);
        // R10: further write-strobe activity with new data is ignored.
        dq_i = 4'h4; we_n = 1'b1; settle();
        we_n = 1'b0; settle();
        end_cycle();
        check(last_row == 9'd9 && ref_cnt == exp_ref, "R9 refresh on read-turned-load",
              last_row, 9'd9);
        read_back(v, s);
        check(v == 4'h9, "R8 loaded on we fall", v, 4'h9);
        check(v != 4'h4, "R10 no second load", v, 4'h9);

        // R7: row strobe rises while output enable still low.
        start_color(9'd3);
        exp_ref++;
        cas_n = 1'b0; settle();
        oe_n = 1'b0;  settle();
        check(dq_oe == 1'b1, "R6 drive active", dq_oe, 1);
        ras_n = 1'b1; settle();
        check(!dq_oe, "R7 drive off at row rise", dq_oe, 0);
        end_cycle();
        check(ref_cnt == exp_ref, "R9 pulse count", ref_cnt, exp_ref);

        // R1: reset mid-life clears register.
        rst_n = 1'b0; settle();
        rst_n = 1'b1; settle();
        read_back(v, s);
        check(v == 4'h0, "R1 reset clears register", v, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule